// File: doc/BRIEF.md
# Signed Power-of-Two Scaling Shifter

This block multiplies or divides a two's complement word by a fixed power of two, 2^K, where K is set at elaboration time. A direction input selects between scaling up (a left shift) and scaling down (an arithmetic right shift). It is meant for fixed-point datapaths that move a value between formats, for example dropping two fraction bits to turn a Q4.4 sample into a Q6.2 one, or regaining headroom before a later stage.

Scaling down has three rounding behaviours. The first is a plain floor, which is just the arithmetic shift. The second truncates toward zero, so the result matches integer division. The third rounds to the nearest value, with ties going away from zero. The last two add a bias that depends on the sign of the value before shifting. This bias is formed one bit wider than the data, so it can never wrap.

Scaling up detects overflow from the bits that the shift pushes out of the word. It then either wraps or clamps to the signed limit on the side of the input's sign. Each accepted input produces one registered result a cycle later.

Top module: `pow2_scale_shifter`

## Requirements
- R1: While reset is held, and after it until the first accepted input, out_valid, out_data and out_ovf are all 0.
- R2: out_valid in a cycle equals in_valid of the cycle before. out_data and out_ovf change only in the cycle after in_valid is 1; in every other cycle they hold their values.
- R3: With in_dir = 0 (down) and in_rmode = 2'b00, out_data is floor(x / 2^K), with x read as signed.
- R4: With in_dir = 0 and in_rmode = 2'b01, out_data is x / 2^K truncated toward zero. Negative inputs are biased by 2^K-1 before the shift, and non-negative inputs are shifted with no bias. For K=1, -5 gives -2.
- R5: With in_dir = 0 and in_rmode = 2'b10, out_data is x / 2^K rounded to the nearest integer, with halves going away from zero. For N=8, K=2: 8'b0010_0010 gives 8'b0000_1001, and 8'b1110_1111 gives 8'b1111_1100.
- R6: With in_dir = 0 and in_rmode = 2'b11, the result equals the floor result of R3.
- R7: With in_dir = 0, out_ovf is 0 for every input. With in_dir = 1, in_rmode has no effect on out_data or out_ovf.
- R8: With in_dir = 1, out_ovf is 1 exactly when the top K+1 bits of in_data are not all equal.
- R9: With in_dir = 1 and no overflow, out_data equals x * 2^K.
- R10: With in_dir = 1, in_sat_en = 0 and an overflow, out_data is the low N bits of x * 2^K (the wrapped value).
- R11: With in_dir = 1, in_sat_en = 1 and an overflow, out_data is the signed maximum (0 followed by ones) when x is non-negative, and the signed minimum (1 followed by zeros) when x is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the input word and its controls for one cycle |
| in_data | input | DATA_W | Signed input word |
| in_dir | input | 1 | 1 scales up (multiply), 0 scales down (divide) |
| in_rmode | input | 2 | Rounding for scaling down: 00 floor, 01 toward zero, 10 nearest, 11 floor |
| in_sat_en | input | 1 | 1 clamps an overflowing up-scale to the signed limit |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_data | output | DATA_W | Registered scaled result |
| out_ovf | output | 1 | Up-scale overflowed for this result |

## Verification
Overflow detection and saturation act on the same result in the same cycle. The flag must rise, and the clamped limit must replace the wrapped value together. To provoke this, every input word of an 8-bit, K=2 instance is scaled up with saturation both off and on. The flag and the data are then compared against a product computed as an integer in the bench, which decides both overflow and the clamp side from the input's sign. The bench also sweeps all words through all four rounding codes, with expected quotients worked out by integer division.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    typedef enum logic [1:0] {
        RND_FLOOR   = 2'b00,
        RND_ZERO    = 2'b01,
        RND_NEAREST = 2'b10,
        RND_FLOOR_B = 2'b11
    } rnd_mode_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } scale_dir_e;

endpackage

// File: rtl/scaler_bias.sv
// Sign-dependent pre-shift bias, one bit wider than the data word.
module scaler_bias
    import scaler_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 4
) (
    input  logic              neg,
    input  rnd_mode_e         mode,
    output logic [DATA_W:0]   bias
);
    localparam int EXT_W = DATA_W + 1;
    // all ones below the shift point: pushes any negative fraction up to the next integer
    localparam logic [EXT_W-1:0] CEIL_B = EXT_W'((64'd1 << SHIFT_K) - 64'd1);
    // half of the dropped weight
    localparam logic [EXT_W-1:0] HALF_B = EXT_W'(64'd1 << (SHIFT_K - 1));
    // for negatives: subtract half, then truncate toward zero == floor after (half - 1)
    localparam logic [EXT_W-1:0] HALF_N = EXT_W'((64'd1 << (SHIFT_K - 1)) - 64'd1);

    always_comb begin
        bias = '0;
        case (mode)
            RND_ZERO:    bias = neg ? CEIL_B : '0;
            RND_NEAREST: bias = neg ? HALF_N : HALF_B;
            default:     bias = '0;
        endcase
    end

endmodule

// File: rtl/scaler_down.sv
// Divide by 2^K: biased add at N+1 bits followed by an arithmetic shift.
module scaler_down
    import scaler_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 4
) (
    input  logic [DATA_W-1:0] x,
    input  rnd_mode_e         mode,
    output logic [DATA_W-1:0] y
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] x_ext;
    logic [EXT_W-1:0] bias;
    logic [EXT_W-1:0] sum;

    scaler_bias #(
        .DATA_W  (DATA_W),
        .SHIFT_K (SHIFT_K)
    ) bias_i (
        .neg  (x[DATA_W-1]),
        .mode (mode),
        .bias (bias)
    );

    always_comb begin
        x_ext = {x[DATA_W-1], x};
        sum   = x_ext + bias;
        y     = DATA_W'($signed(sum) >>> SHIFT_K);
    end

endmodule

// File: rtl/scaler_up.sv
// Multiply by 2^K with overflow detection and optional clamping.
module scaler_up #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 4
) (
    input  logic [DATA_W-1:0] x,
    input  logic              sat_en,
    output logic [DATA_W-1:0] y,
    output logic              ovf
);
    localparam int TOP_W = SHIFT_K + 1;
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic [TOP_W-1:0]  top_bits;
    logic [DATA_W-1:0] wrapped;

    always_comb begin
        top_bits = x[DATA_W-1 -: TOP_W];
        // the dropped bits and the new sign bit must all agree
        ovf      = !((&top_bits) || !(|top_bits));
        wrapped  = x << SHIFT_K;
        if (ovf && sat_en) begin
            y = x[DATA_W-1] ? NEG_LIM : POS_LIM;
        end else begin
            y = wrapped;
        end
    end

endmodule

// File: rtl/pow2_scale_shifter.sv
module pow2_scale_shifter
    import scaler_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_dir,
    input  logic [1:0]        in_rmode,
    input  logic              in_sat_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovf
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              ovf;
    } out_state_t;

    out_state_t st_d, st_q;

    rnd_mode_e         mode_sel;
    scale_dir_e        dir_sel;
    logic [DATA_W-1:0] dn_y;
    logic [DATA_W-1:0] up_y;
    logic              up_ovf;

    assign mode_sel = rnd_mode_e'(in_rmode);
    assign dir_sel  = scale_dir_e'(in_dir);

    scaler_down #(
        .DATA_W  (DATA_W),
        .SHIFT_K (SHIFT_K)
    ) down_i (
        .x    (in_data),
        .mode (mode_sel),
        .y    (dn_y)
    );

    scaler_up #(
        .DATA_W  (DATA_W),
        .SHIFT_K (SHIFT_K)
    ) up_i (
        .x      (in_data),
        .sat_en (in_sat_en),
        .y      (up_y),
        .ovf    (up_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (dir_sel == DIR_UP) begin
                st_d.data = up_y;
                st_d.ovf  = up_ovf;
            end else begin
                st_d.data = dn_y;
                st_d.ovf  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_ovf   = st_q.ovf;

endmodule

// File: rtl/pow2_scale_shifter_chk.sv
module pow2_scale_shifter_chk #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_dir,
    input logic              in_sat_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ovf
);
    localparam int TOP_W = SHIFT_K + 1;
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic [TOP_W-1:0] in_top;
    logic             top_uniform;
    assign in_top      = in_data[DATA_W-1 -: TOP_W];
    assign top_uniform = (in_top == '0) || (in_top == '1);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

    // R7
    down_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dir) |=> !out_ovf);

    // R8
    ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir && !top_uniform) |=> out_ovf);

    // R9
    exact_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir && top_uniform) |=>
            (!out_ovf && out_data == DATA_W'($past(in_data) << SHIFT_K)));

    // R11
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir && in_sat_en && !top_uniform) |=>
            (out_data == ($past(in_data[DATA_W-1]) ? NEG_LIM : POS_LIM)));

endmodule

bind pow2_scale_shifter pow2_scale_shifter_chk #(
    .DATA_W  (DATA_W),
    .SHIFT_K (SHIFT_K)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_dir    (in_dir),
    .in_sat_en (in_sat_en),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/pow2_scale_shifter_tb_top.sv
module pow2_scale_shifter_tb_top;
    localparam int DW = 8;
    localparam int KS = 2;
    localparam int DIV = 1 << KS;
    localparam int SMAX = (1 << (DW - 1)) - 1;
    localparam int SMIN = -(1 << (DW - 1));
    localparam int MASK = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_dir = 1'b0;
    logic [1:0]    in_rmode = 2'b00;
    logic          in_sat_en = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ovf;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pow2_scale_shifter #(
        .DATA_W  (DW),
        .SHIFT_K (KS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_dir    (in_dir),
        .in_rmode  (in_rmode),
        .in_sat_en (in_sat_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ovf   (out_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int as_signed(input int v);
        return (v > SMAX) ? v - (1 << DW) : v;
    endfunction

    function automatic int exp_down(input int x, input int mode);
        int q;
        if (mode == 1) begin
            q = x / DIV;
        end else if (mode == 2) begin
            q = (x >= 0) ? (x + DIV / 2) / DIV : (x - DIV / 2) / DIV;
        end else begin
            q = x / DIV;
            if ((x % DIV) != 0 && x < 0) q = q - 1;
        end
        return q & MASK;
    endfunction

    task automatic send(input int v, input bit dir, input int mode, input bit sat);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = DW'(v);
        in_dir    = dir;
        in_rmode  = 2'(mode);
        in_sat_en = sat;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 data in reset", int'(out_data), 0);
        chk("R1 ovf in reset", int'(out_ovf), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 data after reset", int'(out_data), 0);

        // R5 stated examples
        send(8'h22, 1'b0, 2, 1'b0);
        chk("R5 example pos", int'(out_data), 8'h09);
        send(8'hEF, 1'b0, 2, 1'b0);
        chk("R5 example neg", int'(out_data), 8'hFC);

        // R2 valid pulse then hold while idle with changing inputs
        send(8'h40, 1'b1, 0, 1'b0);
        chk("R2 valid after accept", int'(out_valid), 1);
        in_data = 8'h13; in_dir = 1'b0; in_rmode = 2'b10;
        @(negedge clk);
        chk("R2 valid drops", int'(out_valid), 0);
        chk("R2 data holds", int'(out_data), 8'h00);
        chk("R2 ovf holds", int'(out_ovf), 1);

        // sweep down direction, all modes
        for (int v = 0; v < 256; v++) begin
            for (int m = 0; m < 4; m++) begin
                int xs;
                xs = as_signed(v);
                send(v, 1'b0, m, v[0]);
                case (m)
                    0: chk("R3 floor", int'(out_data), exp_down(xs, 0));
                    1: chk("R4 toward zero", int'(out_data), exp_down(xs, 1));
                    2: chk("R5 nearest", int'(out_data), exp_down(xs, 2));
                    default: chk("R6 alt floor", int'(out_data), exp_down(xs, 0));
                endcase
                chk("R7 down no ovf", int'(out_ovf), 0);
            end
        end

        // R4 sign boundary: -1 and +1 both go to 0 toward zero
        send(8'hFF, 1'b0, 1, 1'b0);
        chk("R4 minus one", int'(out_data), 0);

        // sweep up direction, saturation off/on, two rounding codes
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 4; m += 3) begin
                    int xs, p, e;
                    bit of;
                    xs = as_signed(v);
                    p  = xs * DIV;
                    of = (p > SMAX) || (p < SMIN);
                    send(v, 1'b1, m, s[0]);
                    chk("R8 ovf flag", int'(out_ovf), int'(of));
                    if (!of) begin
                        chk("R9 exact product", int'(out_data), p & MASK);
                    end else if (s == 0) begin
                        chk("R10 wrapped", int'(out_data), p & MASK);
                    end else begin
                        e = (xs < 0) ? SMIN : SMAX;
                        chk("R11 clamp", int'(out_data), e & MASK);
                    end
                    if (m != 0) chk("R7 mode ignored up", int'(out_valid), 1);
                end
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule